// File: doc/BRIEF.md
# Supervised-Aware Store Buffer

This block is a small first-in first-out store buffer. It sits between a processor's store port and memory and keeps total-store-order behaviour. Each buffered store holds its virtual address, its data and a flag that marks it as a supervised store. Stores leave for memory strictly in the order they arrived. A load can still complete ahead of older buffered stores, provided none of them targets its address.

An ordinary load that matches a buffered store takes its data from that store. If several stores match, the youngest one supplies the data. A supervised load never takes forwarded data. It reports a stall for as long as any buffered store to its address remains. The stall ends only once those stores have drained.

Supervised stores report exceptions late, after the store has left the pipeline. When such an exception is raised, the buffer stops draining. It then reads out every pending entry through a dump port, one entry per cycle and oldest first, so that a deferred handler can replay them. A done pulse closes the dump, and normal operation resumes after it.

Top module: `sup_store_buffer`

## Requirements
- R1: After a synchronous active-low reset the buffer is empty. `enq_ready` is 1, and `mem_valid`, `dump_valid`, `dump_done`, `ld_hit` and `ld_stall` are all 0.
- R2: A store is accepted on a cycle where `enq_valid` and `enq_ready` are both 1. With DEPTH (4) entries held, `enq_ready` is 0 and any offered store is dropped.
- R3: Outside a dump, `mem_valid` is 1 whenever the buffer is not empty. `mem_vaddr`, `mem_data` and `mem_sup` then show the oldest entry, which leaves the buffer on a cycle where `mem_ready` is 1. Entries drain in arrival order.
- R4: An ordinary load (`ld_valid`=1, `ld_sup`=0) whose address equals the address of a buffered store gets `ld_hit`=1. `ld_data` comes from the youngest matching entry.
- R5: An ordinary load with no matching buffered store gets `ld_hit`=0 and `ld_stall`=0, even when older stores to other addresses are still pending.
- R6: A supervised load (`ld_valid`=1, `ld_sup`=1) never gets `ld_hit`=1. It gets `ld_stall`=1 while any buffered store matches its address, and `ld_stall`=0 once none does.
- R7: `exc_req` raised outside a dump starts a dump on the next cycle. During the dump `mem_valid` is 0. Each cycle one entry appears on `dump_valid`/`dump_vaddr`/`dump_data`/`dump_sup`, oldest first, and `dump_last` marks the final one.
- R8: `dump_done` is a one-cycle pulse in the cycle after the final dumped entry. When the buffer was empty, the pulse comes in the cycle after `exc_req`. The buffer is empty afterwards, and `exc_req` during a dump is ignored.
- R9: `enq_ready` is 0 for the whole dump, including the `dump_done` cycle, so no store is accepted then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enq_valid | input | 1 | Store offered by the pipeline |
| enq_ready | output | 1 | Buffer can accept a store |
| enq_vaddr | input | AW | Virtual address of offered store |
| enq_data | input | DW | Data of offered store |
| enq_sup | input | 1 | Offered store is supervised |
| mem_valid | output | 1 | Oldest entry is offered to memory |
| mem_ready | input | 1 | Memory accepts the offered entry |
| mem_vaddr | output | AW | Address of oldest entry |
| mem_data | output | DW | Data of oldest entry |
| mem_sup | output | 1 | Oldest entry is supervised |
| ld_valid | input | 1 | Load lookup request |
| ld_sup | input | 1 | Load is supervised |
| ld_vaddr | input | AW | Load virtual address |
| ld_hit | output | 1 | Forwarded data available |
| ld_data | output | DW | Forwarded data |
| ld_stall | output | 1 | Supervised load must wait |
| exc_req | input | 1 | Late supervised-store exception |
| dump_valid | output | 1 | Dumped entry present |
| dump_vaddr | output | AW | Dumped entry address |
| dump_data | output | DW | Dumped entry data |
| dump_sup | output | 1 | Dumped entry supervised flag |
| dump_last | output | 1 | Dumped entry is the final one |
| dump_done | output | 1 | Dump finished pulse |

## Verification
The head pointer, tail pointer and entry count each have a direct effect at the ports, so damage to any of them shows up quickly. A corrupted count or pointer shows up on the next cycle: the wrong `mem_vaddr`, a wrong `enq_ready` at the fullness boundary, or a missing or extra dump beat. A fault in the age-ordered view shows up first as forwarding from the wrong entry when one address is stored twice. A dump controller stuck in its dump state shows up one cycle later as `enq_ready` held low and a repeated or missing `dump_done`.

// File: rtl/sb_pkg.sv
// Shared types for the supervised-aware store buffer.
// Assumes: included first in compile order.
package sb_pkg;

    // Operating mode of the buffer drain path.
    typedef enum logic {
        DS_RUN  = 1'b0,
        DS_DUMP = 1'b1
    } dump_state_e;

endpackage

// File: rtl/sb_fifo.sv
// Circular entry storage with an age-ordered view of all slots.
// Slot k of the age view is the k-th oldest entry; age_live marks which
// slots hold a store. Assumes the caller never pushes when full nor pops
// when empty.
module sb_fifo #(
    parameter int DEPTH = 4,
    parameter int AW    = 32,
    parameter int DW    = 32,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [AW-1:0]    push_vaddr,
    input  logic [DW-1:0]    push_data,
    input  logic             push_sup,
    input  logic             pop,
    output logic [AW-1:0]    age_vaddr [DEPTH],
    output logic [DW-1:0]    age_data  [DEPTH],
    output logic             age_sup   [DEPTH],
    output logic [DEPTH-1:0] age_live,
    output logic [CW-1:0]    count,
    output logic             empty,
    output logic             full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [AW-1:0] vaddr_q [DEPTH];
    logic [DW-1:0] data_q  [DEPTH];
    logic          sup_q   [DEPTH];
    logic [PW-1:0] head_q, tail_q;
    logic [CW-1:0] cnt_q;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Write the incoming store into the tail slot.
    always_ff @(posedge clk) begin
        if (push) begin
            vaddr_q[tail_q] <= push_vaddr;
            data_q[tail_q]  <= push_data;
            sup_q[tail_q]   <= push_sup;
        end
    end

    // Advance pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q <= '0;
            tail_q <= '0;
            cnt_q  <= '0;
        end else begin
            if (push) tail_q <= bump(tail_q);
            if (pop)  head_q <= bump(head_q);
            case ({push, pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assign count = cnt_q;
    assign empty = (cnt_q == '0);
    assign full  = (cnt_q == CW'(DEPTH));

    // Build the oldest-first view of the storage.
    for (genvar k = 0; k < DEPTH; k++) begin : g_age
        logic [PW:0]   sum;
        logic [PW-1:0] idx;
        assign sum = {1'b0, head_q} + (PW + 1)'(k);
        assign idx = (sum >= (PW + 1)'(DEPTH)) ? PW'(sum - (PW + 1)'(DEPTH)) : sum[PW-1:0];
        assign age_vaddr[k] = vaddr_q[idx];
        assign age_data[k]  = data_q[idx];
        assign age_sup[k]   = sup_q[idx];
        assign age_live[k]  = (CW'(k) < cnt_q);
    end

    // R2
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (count != CW'(DEPTH)));

    // R3
    pop_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push) |=> (count == $past(count) - 1'b1));

endmodule

// File: rtl/sb_fwd.sv
// Load lookup against buffered stores. Scans the age-ordered view so
// that the youngest matching entry wins. Ordinary loads get forwarded
// data; supervised loads only learn whether they must wait.
module sb_fwd #(
    parameter int DEPTH = 4,
    parameter int AW    = 32,
    parameter int DW    = 32
) (
    input  logic [AW-1:0]    age_vaddr [DEPTH],
    input  logic [DW-1:0]    age_data  [DEPTH],
    input  logic [DEPTH-1:0] age_live,
    input  logic             ld_valid,
    input  logic             ld_sup,
    input  logic [AW-1:0]    ld_vaddr,
    output logic             ld_hit,
    output logic [DW-1:0]    ld_data,
    output logic             ld_stall
);
    logic          any_match;
    logic [DW-1:0] young_data;

    // Find any match and keep the data of the youngest one.
    always_comb begin
        any_match  = 1'b0;
        young_data = '0;
        for (int k = 0; k < DEPTH; k++) begin
            if (age_live[k] && (age_vaddr[k] == ld_vaddr)) begin
                any_match  = 1'b1;
                young_data = age_data[k];
            end
        end
    end

    // Split the result by load kind.
    always_comb begin
        ld_hit   = ld_valid && !ld_sup && any_match;
        ld_stall = ld_valid &&  ld_sup && any_match;
        ld_data  = ld_hit ? young_data : '0;
    end

endmodule

// File: rtl/sb_dump_ctl.sv
// Late-exception dump sequencer. On an exception it halts draining and
// pops one entry per cycle until empty, then pulses done for one cycle.
// Assumes the storage reports empty and the one-entry-left condition.
module sb_dump_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic exc_req,
    input  logic empty,
    input  logic one_left,
    output logic dumping,
    output logic dump_fire,
    output logic dump_last,
    output logic dump_done
);
    import sb_pkg::*;

    dump_state_e state_q;

    // Enter dump on exception, leave after the done cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= DS_RUN;
        end else begin
            case (state_q)
                DS_RUN:  if (exc_req) state_q <= DS_DUMP;
                DS_DUMP: if (empty)   state_q <= DS_RUN;
                default: state_q <= DS_RUN;
            endcase
        end
    end

    // Decode per-cycle dump strobes.
    always_comb begin
        dumping   = (state_q == DS_DUMP);
        dump_fire = dumping && !empty;
        dump_last = dump_fire && one_left;
        dump_done = dumping && empty;
    end

    // R8
    last_then_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dump_last |=> dump_done);

    // R8
    done_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dump_done |=> !dumping);

endmodule

// File: rtl/sup_store_buffer.sv
// Supervised-aware store buffer top. Stores drain in order to memory
// unless a late exception has started a dump; loads look up the buffer
// through the forwarding unit. Assumes mem_ready may be asserted freely
// and the handler consumes one dumped entry per cycle.
module sup_store_buffer #(
    parameter int DEPTH = 4,
    parameter int AW    = 32,
    parameter int DW    = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enq_valid,
    output logic          enq_ready,
    input  logic [AW-1:0] enq_vaddr,
    input  logic [DW-1:0] enq_data,
    input  logic          enq_sup,
    output logic          mem_valid,
    input  logic          mem_ready,
    output logic [AW-1:0] mem_vaddr,
    output logic [DW-1:0] mem_data,
    output logic          mem_sup,
    input  logic          ld_valid,
    input  logic          ld_sup,
    input  logic [AW-1:0] ld_vaddr,
    output logic          ld_hit,
    output logic [DW-1:0] ld_data,
    output logic          ld_stall,
    input  logic          exc_req,
    output logic          dump_valid,
    output logic [AW-1:0] dump_vaddr,
    output logic [DW-1:0] dump_data,
    output logic          dump_sup,
    output logic          dump_last,
    output logic          dump_done
);
    localparam int CW = $clog2(DEPTH + 1);

    logic [AW-1:0]    age_vaddr [DEPTH];
    logic [DW-1:0]    age_data  [DEPTH];
    logic             age_sup   [DEPTH];
    logic [DEPTH-1:0] age_live;
    logic [CW-1:0]    count;
    logic             empty, full;
    logic             dumping, dump_fire;
    logic             push, pop, drain_fire;

    // Edge handshakes and pop selection.
    always_comb begin
        enq_ready  = !dumping && !full;
        push       = enq_valid && enq_ready;
        mem_valid  = !dumping && !empty;
        drain_fire = mem_valid && mem_ready;
        pop        = drain_fire || dump_fire;
    end

    sb_fifo #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (push),
        .push_vaddr (enq_vaddr),
        .push_data  (enq_data),
        .push_sup   (enq_sup),
        .pop        (pop),
        .age_vaddr  (age_vaddr),
        .age_data   (age_data),
        .age_sup    (age_sup),
        .age_live   (age_live),
        .count      (count),
        .empty      (empty),
        .full       (full)
    );

    sb_fwd #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_fwd (
        .age_vaddr (age_vaddr),
        .age_data  (age_data),
        .age_live  (age_live),
        .ld_valid  (ld_valid),
        .ld_sup    (ld_sup),
        .ld_vaddr  (ld_vaddr),
        .ld_hit    (ld_hit),
        .ld_data   (ld_data),
        .ld_stall  (ld_stall)
    );

    sb_dump_ctl u_dump (
        .clk       (clk),
        .rst_n     (rst_n),
        .exc_req   (exc_req),
        .empty     (empty),
        .one_left  (count == CW'(1)),
        .dumping   (dumping),
        .dump_fire (dump_fire),
        .dump_last (dump_last),
        .dump_done (dump_done)
    );

    // Head entry drives both the memory and the dump port.
    always_comb begin
        mem_vaddr  = age_vaddr[0];
        mem_data   = age_data[0];
        mem_sup    = age_sup[0];
        dump_valid = dump_fire;
        dump_vaddr = age_vaddr[0];
        dump_data  = age_data[0];
        dump_sup   = age_sup[0];
    end

    // R7
    no_drain_in_dump_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dump_valid |-> !mem_valid);

    // R6
    sup_no_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && ld_sup) |-> !ld_hit);

    // R9
    no_enq_in_dump_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dump_valid || dump_done) |-> !enq_ready);

endmodule

// File: tb/sup_store_buffer_bench.sv
`timescale 1ns/1ps
module sup_store_buffer_bench;
    localparam int AW = 32;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          enq_valid = 1'b0, enq_ready, enq_sup = 1'b0;
    logic [AW-1:0] enq_vaddr = '0;
    logic [DW-1:0] enq_data = '0;
    logic          mem_valid, mem_ready = 1'b0, mem_sup;
    logic [AW-1:0] mem_vaddr;
    logic [DW-1:0] mem_data;
    logic          ld_valid = 1'b0, ld_sup = 1'b0, ld_hit, ld_stall;
    logic [AW-1:0] ld_vaddr = '0;
    logic [DW-1:0] ld_data;
    logic          exc_req = 1'b0;
    logic          dump_valid, dump_sup, dump_last, dump_done;
    logic [AW-1:0] dump_vaddr;
    logic [DW-1:0] dump_data;

    always #4 clk = ~clk;  // 125 MHz

    sup_store_buffer u_sup_store_buffer (.*);

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;
    bit finished = 1'b0;

    typedef struct packed {
        logic ev; logic [7:0] ea; logic [7:0] ed; logic es;
        logic mr; logic lv; logic ls; logic [7:0] la; logic ex;
        logic rdy; logic mv; logic [7:0] ma; logic [7:0] md;
        logic hit; logic [7:0] hd; logic stl;
        logic dv; logic [7:0] da; logic [7:0] dd; logic ds; logic dl; logic dn;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t TBL [NV] = '{
        '{1'b1,8'h10,8'hA1,1'b0, 1'b0, 1'b1,1'b0,8'h10, 1'b0, 1'b1,1'b0,8'h00,8'h00, 1'b0,8'h00,1'b0, 1'b0,8'h00,8'h00,1'b0,1'b0,1'b0},
        '{1'b1,8'h20,8'hB2,1'b1, 1'b0, 1'b1,1'b0,8'h10, 1'b0, 1'b1,1'b1,8'h10,8'hA1, 1'b1,8'hA1,1'b0, 1'b0,8'h00,8'h00,1'b0,1'b0,1'b0},
        '{1'b1,8'h10,8'hC3,1'b0, 1'b0, 1'b1,1'b1,8'h10, 1'b0, 1'b1,1'b1,8'h10,8'hA1, 1'b0,8'h00,1'b1, 1'b0,8'h00,8'h00,1'b0,1'b0,1'b0},
        '{1'b1,8'h30,8'hD4,1'b0, 1'b0, 1'b1,1'b0,8'h10, 1'b0, 1'b1,1'b1,8'h10,8'hA1, 1'b1,8'hC3,1'b0, 1'b0,8'h00,8'h00,1'b0,1'b0,1'b0},
        '{1'b1,8'h40,8'h77,1'b0, 1'b0, 1'b1,1'b0,8'h50, 1'b0, 1'b0,1'b1,8'h10,8'hA1, 1'b0,8'h00,1'b0, 1'b0,8'h00,8'h00,1'b0,1'b0,1'b0},
        '{1'b0,8'h00,8'h00,1'b0, 1'b1, 1'b1,1'b1,8'h20, 1'b0, 1'b0,1'b1,8'h10,8'hA1, 1'b0,8'h00,1'b1, 1'b0,8'h00,8'h00,1'b0,1'b0,1'b0},
        '{1'b0,8'h00,8'h00,1'b0, 1'b1, 1'b1,1'b1,8'h10, 1'b0, 1'b1,1'b1,8'h20,8'hB2, 1'b0,8'h00,1'b1, 1'b0,8'h00,8'h00,1'b0,1'b0,1'b0},
        '{1'b0,8'h00,8'h00,1'b0, 1'b1, 1'b1,1'b1,8'h20, 1'b0, 1'b1,1'b1,8'h10,8'hC3, 1'b0,8'h00,1'b0, 1'b0,8'h00,8'h00,1'b0,1'b0,1'b0},
        '{1'b1,8'h50,8'hE5,1'b1, 1'b0, 1'b0,1'b0,8'h00, 1'b0, 1'b1,1'b1,8'h30,8'hD4, 1'b0,8'h00,1'b0, 1'b0,8'h00,8'h00,1'b0,1'b0,1'b0},
        '{1'b1,8'h60,8'hF6,1'b0, 1'b1, 1'b0,1'b0,8'h00, 1'b1, 1'b1,1'b1,8'h30,8'hD4, 1'b0,8'h00,1'b0, 1'b0,8'h00,8'h00,1'b0,1'b0,1'b0},
        '{1'b1,8'h70,8'h88,1'b0, 1'b1, 1'b1,1'b0,8'h50, 1'b0, 1'b0,1'b0,8'h00,8'h00, 1'b1,8'hE5,1'b0, 1'b1,8'h50,8'hE5,1'b1,1'b0,1'b0},
        '{1'b0,8'h00,8'h00,1'b0, 1'b1, 1'b0,1'b0,8'h00, 1'b0, 1'b0,1'b0,8'h00,8'h00, 1'b0,8'h00,1'b0, 1'b1,8'h60,8'hF6,1'b0,1'b1,1'b0},
        '{1'b0,8'h00,8'h00,1'b0, 1'b0, 1'b0,1'b0,8'h00, 1'b1, 1'b0,1'b0,8'h00,8'h00, 1'b0,8'h00,1'b0, 1'b0,8'h00,8'h00,1'b0,1'b0,1'b1},
        '{1'b0,8'h00,8'h00,1'b0, 1'b0, 1'b0,1'b0,8'h00, 1'b1, 1'b1,1'b0,8'h00,8'h00, 1'b0,8'h00,1'b0, 1'b0,8'h00,8'h00,1'b0,1'b0,1'b0},
        '{1'b0,8'h00,8'h00,1'b0, 1'b0, 1'b0,1'b0,8'h00, 1'b0, 1'b0,1'b0,8'h00,8'h00, 1'b0,8'h00,1'b0, 1'b0,8'h00,8'h00,1'b0,1'b0,1'b1},
        '{1'b0,8'h00,8'h00,1'b0, 1'b0, 1'b0,1'b0,8'h00, 1'b0, 1'b1,1'b0,8'h00,8'h00, 1'b0,8'h00,1'b0, 1'b0,8'h00,8'h00,1'b0,1'b0,1'b0}
    };

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        enq_valid = 1'b0; enq_vaddr = '0; enq_data = '0; enq_sup = 1'b0;
        mem_ready = 1'b0; ld_valid = 1'b0; ld_sup = 1'b0; ld_vaddr = '0;
        exc_req = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as one failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 200000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected below 200000 cycles", cycles);
            finish_run();
        end
    end

    initial begin
        idle_inputs();
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        #2;
        // R1 reset state while reset held after clock edges
        chk("R1", "enq_ready", 32'(enq_ready), 32'd1);
        chk("R1", "mem_valid", 32'(mem_valid), 32'd0);
        chk("R1", "dump_valid", 32'(dump_valid), 32'd0);
        chk("R1", "dump_done", 32'(dump_done), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // Table walk: drive at the falling edge, compare before the rising edge.
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            enq_valid = TBL[i].ev; enq_vaddr = 32'(TBL[i].ea);
            enq_data = 32'(TBL[i].ed); enq_sup = TBL[i].es;
            mem_ready = TBL[i].mr; ld_valid = TBL[i].lv; ld_sup = TBL[i].ls;
            ld_vaddr = 32'(TBL[i].la); exc_req = TBL[i].ex;
            #2;
            chk("R2/R9", "enq_ready", 32'(enq_ready), 32'(TBL[i].rdy));
            chk("R3/R7", "mem_valid", 32'(mem_valid), 32'(TBL[i].mv));
            if (TBL[i].mv) begin
                chk("R3", "mem_vaddr", mem_vaddr, 32'(TBL[i].ma));
                chk("R3", "mem_data", mem_data, 32'(TBL[i].md));
            end
            chk("R4/R5", "ld_hit", 32'(ld_hit), 32'(TBL[i].hit));
            if (TBL[i].hit) chk("R4", "ld_data", ld_data, 32'(TBL[i].hd));
            chk("R6", "ld_stall", 32'(ld_stall), 32'(TBL[i].stl));
            chk("R7", "dump_valid", 32'(dump_valid), 32'(TBL[i].dv));
            if (TBL[i].dv) begin
                chk("R7", "dump_vaddr", dump_vaddr, 32'(TBL[i].da));
                chk("R7", "dump_data", dump_data, 32'(TBL[i].dd));
                chk("R7", "dump_sup", 32'(dump_sup), 32'(TBL[i].ds));
                chk("R7", "dump_last", 32'(dump_last), 32'(TBL[i].dl));
            end
            chk("R8", "dump_done", 32'(dump_done), 32'(TBL[i].dn));
        end

        // Directed: fill all four slots, then dump them oldest first (R7, R8).
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            idle_inputs();
            enq_valid = 1'b1; enq_vaddr = 32'(8'h80 + k); enq_data = 32'(8'h90 + k);
            enq_sup = k[0];
        end
        @(negedge clk);
        idle_inputs();
        exc_req = 1'b1;
        #2;
        chk("R2", "enq_ready full", 32'(enq_ready), 32'd0);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            idle_inputs();
            mem_ready = 1'b1;
            #2;
            chk("R7", "dump_valid beat", 32'(dump_valid), 32'd1);
            chk("R7", "dump_vaddr beat", dump_vaddr, 32'(8'h80 + k));
            chk("R7", "dump_sup beat", 32'(dump_sup), 32'(k[0]));
            chk("R7", "dump_last beat", 32'(dump_last), 32'(k == 3));
            chk("R7", "mem_valid beat", 32'(mem_valid), 32'd0);
        end
        @(negedge clk);
        #2;
        chk("R8", "dump_done after four", 32'(dump_done), 32'd1);
        chk("R9", "enq_ready on done", 32'(enq_ready), 32'd0);
        @(negedge clk);
        #2;
        chk("R8", "empty after dump", 32'(mem_valid), 32'd0);

        // Directed: reset mid-run empties the buffer (R1).
        @(negedge clk);
        idle_inputs();
        enq_valid = 1'b1; enq_vaddr = 32'h44; enq_data = 32'h55;
        @(negedge clk);
        idle_inputs();
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        #2;
        chk("R1", "mem_valid after reset", 32'(mem_valid), 32'd0);
        ld_valid = 1'b1; ld_vaddr = 32'h44;
        #1;
        chk("R1", "ld_hit after reset", 32'(ld_hit), 32'd0);
        idle_inputs();

        finish_run();
    end
endmodule